// File: doc/BRIEF.md
# Gated Switching-Time Counter

This block sits between a bank of cells under test and eight output pins. It measures how long one selected cell output takes to change after the cell inputs change. A manual step clock loads the six data lines either into a page register, which picks a group of eight cell outputs, or into a stimulus register, which drives the cell inputs. A page load whose top three bits are all ones does not change the page. It arms a measurement and picks one of the eight outputs in the current page.

After arming, the first stimulus step applies the initial inputs. The second stimulus step applies the modified inputs and captures the selected output as it was just before that step. A counter clocked by a free-running fast clock then advances while the synchronized live output still equals the captured value. It stops for good at the first difference. While timing mode is active, the output pins show the 6-bit count, a strobe taken from a wider divider that runs only while counting, and the captured value. A later page load that is not an arming code returns the pins to normal page output.

Top module: `sw_time_counter`

## Requirements
- R1: On a step edge with page_mode_i high and data_i[5:3] not 3'b111, data_i becomes the page. On a step edge with page_mode_i low, data_i becomes stim_o. In normal mode, pins_o[j] = cell_out_i[8*page+j].
- R2: A page-mode step with data_i[5:3] == 3'b111 keeps the page unchanged and enters timing mode. data_i[2:0] selects bit index j of the current page as the measured output.
- R3: After arming, the first stimulus step only loads stim_o. The second stimulus step loads stim_o and captures the selected output as it was before the step. The captured value is shown on pins_o[7].
- R4: The 6-bit count on pins_o[5:0] advances by one per fast-clock edge while the synchronized selected output equals the captured value, and wraps modulo 64. If the output never changes, the counter keeps running.
- R5: The first difference stops the counter permanently. After that, the count and the strobe hold their values.
- R6: Every measurement starts from zero. Suppose the second stimulus step falls just after a fast edge and the output changes D fast cycles later. The final count is then (D-1) mod 64 for D >= 1, and 0 for D = 0.
- R7: pins_o[6] is the top bit of a DIV_W-bit divider. The divider is cleared together with the counter and advances only when the counter advances.
- R8: Stimulus steps after a measurement has started update stim_o only. They neither recapture the value nor restart the count.
- R9: A page-mode step with data_i[5:3] not 3'b111 leaves timing mode, and pins_o returns to page output.
- R10: In normal mode, a page number of NUM_PAGES or above reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk_i | input | 1 | Free-running measurement clock |
| step_clk_i | input | 1 | Manual step clock for page and stimulus loads |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| page_mode_i | input | 1 | High: step loads page or arming code; low: step loads stimulus |
| data_i | input | 6 | Page number, arming code or stimulus value |
| cell_out_i | input | 8*NUM_PAGES | Live outputs of all cells, page p in bits 8p+7..8p |
| stim_o | output | 6 | Stimulus applied to the cell inputs |
| pins_o | output | 8 | Page output, or {captured, strobe, count} in timing mode |

## Verification
The assertions check every cycle that the page is kept across an arming load, that the capture and the crossing toggle move only on the second stimulus step, and that the counter clears on the enable event, increments while the values match, stops at a mismatch and then holds. Only the bench scenarios can show the end-to-end latency through both synchronizers, which gives the exact final count for a given output delay, including the wrap. The same applies to the strobe value that follows from that count, to the captured value belonging to the right page bit, and to the pins returning to page output afterwards.

// File: rtl/swt_pkg.sv
`timescale 1ns/1ps
package swt_pkg;
  localparam int PAGE_W = 6;
  localparam int LANES  = 8;
  localparam int IDX_W  = $clog2(LANES);
  localparam int CNT_W  = 6;
  localparam logic [2:0] VIRT_TAG = 3'b111;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_INIT,
    PH_MOD,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/swt_sync.sv
`timescale 1ns/1ps
module swt_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/swt_ctrl.sv
`timescale 1ns/1ps
module swt_ctrl
  import swt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_mode_i,
  input  logic [PAGE_W-1:0] data_i,
  input  logic              sel_bit_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [PAGE_W-1:0] stim_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              timing_o,
  output logic              latch_o,
  output logic              go_tgl_o
);
  phase_e            phase_q;
  logic [PAGE_W-1:0] page_q, stim_q;
  logic [IDX_W-1:0]  idx_q;
  logic              latch_q, go_q;
  logic              is_tag;

  assign is_tag = (data_i[PAGE_W-1:PAGE_W-3] == VIRT_TAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      page_q  <= '0;
      stim_q  <= '0;
      idx_q   <= '0;
      latch_q <= 1'b0;
      go_q    <= 1'b0;
    end else if (page_mode_i) begin
      if (is_tag) begin
        idx_q   <= data_i[IDX_W-1:0];
        phase_q <= PH_INIT;
      end else begin
        page_q  <= data_i;
        phase_q <= PH_IDLE;
      end
    end else begin
      stim_q <= data_i;
      if (phase_q == PH_INIT) begin
        phase_q <= PH_MOD;
      end else if (phase_q == PH_MOD) begin
        latch_q <= sel_bit_i;   // value before the new stimulus takes effect
        go_q    <= ~go_q;
        phase_q <= PH_DONE;
      end
    end
  end

  assign page_o   = page_q;
  assign stim_o   = stim_q;
  assign idx_o    = idx_q;
  assign timing_o = (phase_q != PH_IDLE);
  assign latch_o  = latch_q;
  assign go_tgl_o = go_q;

  AST_TAG_KEEPS_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_mode_i && is_tag |=> $stable(page_q) && phase_q == PH_INIT); // R2
  AST_CAPTURE_ONLY_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_q == PH_MOD && !page_mode_i) |=> $stable(latch_q) && $stable(go_q)); // R3
  AST_DONE_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_DONE && !page_mode_i |=> phase_q == PH_DONE); // R8
  AST_EXIT_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_mode_i && !is_tag |=> !timing_o); // R9
endmodule

// File: rtl/swt_meter.sv
`timescale 1ns/1ps
module swt_meter
  import swt_pkg::*;
#(
  parameter int DIV_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_tgl_i,
  input  logic             live_i,
  input  logic             ref_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             strobe_o
);
  logic [1:0]       sync_q;
  logic             go_d_q, go_pulse, live_s, run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;

  swt_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({go_tgl_i, live_i}),
    .q_o   (sync_q)
  );

  assign live_s   = sync_q[0];
  assign go_pulse = sync_q[1] ^ go_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_d_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
    end else begin
      go_d_q <= sync_q[1];
      if (go_pulse) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        div_q <= '0;
      end else if (run_q) begin
        if (live_s != ref_i) begin
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign strobe_o = div_q[DIV_W-1];

  AST_CLEAR_ON_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_pulse |=> cnt_q == '0 && div_q == '0 && run_q); // R6
  AST_COUNT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !go_pulse && live_s == ref_i |=> cnt_q == $past(cnt_q) + 1'b1); // R4
  AST_STOP_ON_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !go_pulse && live_s != ref_i |=> !run_q); // R5
  AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q && !go_pulse |=> $stable(cnt_q) && $stable(div_q)); // R7
endmodule

// File: rtl/sw_time_counter.sv
`timescale 1ns/1ps
module sw_time_counter
  import swt_pkg::*;
#(
  parameter int NUM_PAGES = 54,
  parameter int DIV_W     = 20
) (
  input  logic                       fast_clk_i,
  input  logic                       step_clk_i,
  input  logic                       rst_ni,
  input  logic                       page_mode_i,
  input  logic [PAGE_W-1:0]          data_i,
  input  logic [NUM_PAGES*LANES-1:0] cell_out_i,
  output logic [PAGE_W-1:0]          stim_o,
  output logic [LANES-1:0]           pins_o
);
  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  idx;
  logic              timing, latch, go_tgl, sel_bit, strobe;
  logic [LANES-1:0]  page_bits;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    page_bits = '0;
    for (int p = 0; p < NUM_PAGES; p++) begin
      if (page == PAGE_W'(p)) page_bits = cell_out_i[p*LANES +: LANES];
    end
  end

  assign sel_bit = page_bits[idx];

  swt_ctrl u_ctrl (
    .clk_i      (step_clk_i),
    .rst_ni     (rst_ni),
    .page_mode_i(page_mode_i),
    .data_i     (data_i),
    .sel_bit_i  (sel_bit),
    .page_o     (page),
    .stim_o     (stim_o),
    .idx_o      (idx),
    .timing_o   (timing),
    .latch_o    (latch),
    .go_tgl_o   (go_tgl)
  );

  swt_meter #(.DIV_W(DIV_W)) u_meter (
    .clk_i   (fast_clk_i),
    .rst_ni  (rst_ni),
    .go_tgl_i(go_tgl),
    .live_i  (sel_bit),
    .ref_i   (latch),
    .cnt_o   (cnt),
    .strobe_o(strobe)
  );

  assign pins_o = timing ? {latch, strobe, cnt} : page_bits;
endmodule

// File: tb/sw_time_counter_test.sv
`timescale 1ns/1ps
module sw_time_counter_test;
  localparam int NP = 4;
  localparam int DW = 4;
  localparam int NB = NP * 8;

  logic          fast_clk = 0;
  logic          step_clk = 0;
  logic          rst_n = 0;
  logic          page_mode = 0;
  logic [5:0]    data = 0;
  logic [5:0]    stim_seen = 0;
  logic [NB-1:0] cell_bus;
  logic [5:0]    stim;
  logic [7:0]    pins;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 fast_clk = ~fast_clk;

  sw_time_counter #(.NUM_PAGES(NP), .DIV_W(DW)) uut (
    .fast_clk_i (fast_clk),
    .step_clk_i (step_clk),
    .rst_ni     (rst_n),
    .page_mode_i(page_mode),
    .data_i     (data),
    .cell_out_i (cell_bus),
    .stim_o     (stim),
    .pins_o     (pins)
  );

  function automatic logic [5:0] mask_of(int i);
    return 6'((i * 5 + 1) % 64);
  endfunction

  function automatic logic fbit(int i, logic [5:0] s);
    return (^(s & mask_of(i))) ^ 1'((i >> 1) & 1);
  endfunction

  function automatic logic [7:0] exp_page(int p, logic [5:0] s);
    logic [7:0] r = '0;
    if (p < NP) for (int j = 0; j < 8; j++) r[j] = fbit(8 * p + j, s);
    return r;
  endfunction

  always_comb for (int i = 0; i < NB; i++) cell_bus[i] = fbit(i, stim_seen);

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic pm, logic [5:0] d);
    @(negedge fast_clk);
    page_mode = pm;
    data = d;
    #1 step_clk = 1;
    #1 step_clk = 0;
  endtask

  task automatic measure(int p, int idx, int dly);
    int i = 8 * p + idx;
    logic [5:0] m = mask_of(i);
    logic [5:0] modv = m & (~m + 6'd1);
    int n = (dly == 0) ? 0 : dly - 1;
    logic [7:0] snap;
    step(1, 6'(p));
    step(1, {3'b111, 3'(idx)});
    step(0, 6'd0);
    stim_seen = 0;
    repeat (8) @(posedge fast_clk);
    step(0, modv);
    if (dly == 0) stim_seen = modv;
    else begin
      repeat (dly) @(posedge fast_clk);
      #1 stim_seen = modv;
    end
    repeat (10) @(posedge fast_clk);
    @(negedge fast_clk);
    chk(pins[5:0] == 6'(n % 64), "R6 count", pins[5:0], n % 64);
    chk(pins[7] == fbit(i, 6'd0), "R3/R2 captured", pins[7], fbit(i, 6'd0));
    chk(pins[6] == 1'(((n % 16) >> 3) & 1), "R7 strobe", pins[6], ((n % 16) >> 3) & 1);
    snap = pins;
    repeat (7) @(posedge fast_clk);
    @(negedge fast_clk);
    chk(pins == snap, "R5 frozen", pins, snap);
    step(0, 6'h2A);
    stim_seen = 6'h2A;
    repeat (8) @(posedge fast_clk);
    @(negedge fast_clk);
    chk(pins == snap && stim == 6'h2A, "R8 no restart", pins, snap);
    step(1, 6'(p));
    #0.2;
    chk(pins == exp_page(p, 6'h2A), "R9 exit", pins, exp_page(p, 6'h2A));
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] c1, c2;
    int tg;
    logic sp;
    repeat (3) @(posedge fast_clk);
    @(negedge fast_clk);
    chk(pins == exp_page(0, 0) && stim == 0, "R1 reset", pins, exp_page(0, 0));
    rst_n = 1;
    repeat (2) @(posedge fast_clk);

    for (int p = 0; p < NP + 2; p++) begin
      for (int k = 0; k < 6; k++) begin
        logic [5:0] s = 6'((k * 21 + p * 7) % 64);
        step(1, 6'(p));
        step(0, s);
        stim_seen = s;
        #0.2;
        chk(stim == s, "R1 stim", stim, s);
        chk(pins == exp_page(p, s), (p < NP) ? "R1 page" : "R10 empty page", pins, exp_page(p, s));
      end
    end

    begin
      int dl[8] = '{0, 1, 2, 3, 9, 17, 40, 70};
      for (int k = 0; k < 8; k++) measure(k % NP, (k * 3) % 8, dl[k]);
    end

    // never-changing output: counter keeps running and wraps
    step(1, 6'd2);
    step(1, 6'b111101);
    step(0, 6'd5);
    stim_seen = 6'd5;
    repeat (4) @(posedge fast_clk);
    step(0, 6'd5);
    repeat (10) @(posedge fast_clk);
    @(negedge fast_clk);
    c1 = pins[5:0];
    repeat (40) @(posedge fast_clk);
    @(negedge fast_clk);
    c2 = pins[5:0];
    chk(6'(c2 - c1) == 6'd40, "R4 advance", 6'(c2 - c1), 40);
    c1 = c2;
    repeat (100) @(posedge fast_clk);
    @(negedge fast_clk);
    c2 = pins[5:0];
    chk(6'(c2 - c1) == 6'd36, "R4 wrap", 6'(c2 - c1), 36);
    tg = 0;
    sp = pins[6];
    for (int k = 0; k < 16; k++) begin
      @(negedge fast_clk);
      if (pins[6] != sp) tg++;
      sp = pins[6];
    end
    chk(tg >= 1, "R7 strobe toggles", tg, 1);
    step(1, 6'd1);
    #0.2;
    chk(pins == exp_page(1, 6'd5), "R9 exit free run", pins, exp_page(1, 6'd5));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule